// File: doc/BRIEF.md
# Post-Update Integer Load Unit

This unit executes one integer load at a time for a 64-bit register machine. The load uses post-update addressing. A decoded operation supplies the access size, a zero/sign extension select, an addressing form, a base and a target register index, the base register value and an index register value. The memory read goes out at the base value exactly as it stands. The offset is applied only afterwards, and the sum becomes the new base.

When the read data returns, the unit places the extended value in the target register. In the same cycle it writes the updated address into the base register, using a second write port. Two encodings are not allowed: a base index of zero, and a base index equal to the target index. Either one produces a one-cycle invalid-form pulse. In that case there is no memory traffic and no register write. No condition or status state is touched.

Top module: `postinc_load_unit`

## Requirements
- R1: While `mem_req_valid` is high, `mem_req_addr` equals the `op_base_val` captured at acceptance, with no offset added. `mem_req_size` equals the captured `op_size`, coded 0=byte, 1=halfword, 2=word, 3=doubleword. Address and size stay stable until `mem_req_ready` is seen.
- R2: A byte load (size 0) returns `mem_rsp_data[7:0]` with bits 63:8 cleared, and `op_signed` has no effect on it.
- R3: A halfword load (size 1) returns `mem_rsp_data[15:0]`. The upper 48 bits are zero when `op_signed`=0, and copies of bit 15 when `op_signed`=1.
- R4: A word load (size 2) returns `mem_rsp_data[31:0]`. The upper 32 bits are zero when `op_signed`=0, and copies of bit 31 when `op_signed`=1.
- R5: A doubleword load (size 3) returns all 64 bits of `mem_rsp_data` unchanged, and `op_signed` has no effect on it.
- R6: Form 0 (displacement) produces an updated base equal to the old base plus `op_imm[15:0]` sign-extended to 64 bits.
- R7: Form 1 (scaled displacement) produces an updated base equal to the old base plus `{op_imm[13:0],2'b00}` sign-extended from bit 15. `op_imm[15:14]` are ignored.
- R8: Forms 2 and 3 (indexed) produce an updated base equal to the old base plus the full 64-bit `op_index_val`, with wraparound.
- R9: An operation accepted with `op_base_idx`=0 or `op_base_idx`=`op_tgt_idx` raises `invalid_form` for exactly the next cycle. It issues no memory request and performs no writeback.
- R10: In the cycle where `mem_rsp_valid` is high for an outstanding load, `wb_tgt_we` and `wb_base_we` are both high. They carry the captured target and base indices and the data from R2–R8. At no other time are they high.
- R11: `op_ready` is low from the cycle after a valid operation is accepted up to and including its response cycle. Each operation issues exactly one request.
- R12: After reset, `op_ready` is 1, and `mem_req_valid`, `wb_tgt_we`, `wb_base_we` and `invalid_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit idle, operation accepted this cycle if valid |
| op_size | input | 2 | Access size code |
| op_signed | input | 1 | Sign-extend select |
| op_form | input | 2 | Addressing form code |
| op_imm | input | 16 | Displacement field |
| op_base_idx | input | 5 | Base register index |
| op_tgt_idx | input | 5 | Target register index |
| op_base_val | input | 64 | Base register value |
| op_index_val | input | 64 | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified, big-endian |
| wb_tgt_we | output | 1 | Target register write enable |
| wb_tgt_idx | output | 5 | Target register index |
| wb_tgt_data | output | 64 | Extended load data |
| wb_base_we | output | 1 | Base register write enable |
| wb_base_idx | output | 5 | Base register index |
| wb_base_data | output | 64 | Updated base address |
| invalid_form | output | 1 | Invalid encoding pulse |

## Verification
Suppose the captured operation register is wrong, or gets overwritten after acceptance. The error then shows on `mem_req_addr` in the first request cycle, or on the writeback data in the response cycle. The bench therefore scrambles the operation inputs right after acceptance. A sequencer fault shows within one cycle: a missing or doubled request, `op_ready` rising early, or writeback enables that are not paired. A bad extension or update path appears only in the response cycle, so every size, sign and form combination, plus both invalid cases, is driven through to its response.

// File: rtl/pul_pkg.sv
// Shared encodings for the post-update load unit.
// Assumes the size and form codes are supplied already decoded.
package pul_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FM_DISP   = 2'd0,
        FM_DISPX4 = 2'd1,
        FM_INDEX  = 2'd2,
        FM_RSVD   = 2'd3
    } addr_form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pul_addr_calc.sv
// Computes the post-update base: old base plus a sign-extended displacement,
// a scaled sign-extended displacement, or the full index operand.
// Assumes XLEN is wider than DISP_W and than SDISP_W+SCALE. Wraps modulo 2^XLEN.
module pul_addr_calc #(
    parameter int XLEN    = 64,
    parameter int DISP_W  = 16,
    parameter int SDISP_W = 14,
    parameter int SCALE   = 2
) (
    input  logic [1:0]        form,
    input  logic [DISP_W-1:0] imm,
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    output logic [XLEN-1:0]   updated
);
    import pul_pkg::*;

    localparam int SD_FULL = SDISP_W + SCALE;

    logic [XLEN-1:0]    disp_ext;
    logic [SD_FULL-1:0] sdisp_raw;
    logic [XLEN-1:0]    sdisp_ext;
    logic [XLEN-1:0]    addend;

    // Widen the plain and scaled displacement fields with sign fill.
    always_comb begin
        disp_ext  = {{(XLEN-DISP_W){imm[DISP_W-1]}}, imm};
        sdisp_raw = {imm[SDISP_W-1:0], {SCALE{1'b0}}};
        sdisp_ext = {{(XLEN-SD_FULL){sdisp_raw[SD_FULL-1]}}, sdisp_raw};
    end

    // Choose the addend by form; the reserved code behaves as indexed.
    always_comb begin
        unique case (addr_form_e'(form))
            FM_DISP:   addend = disp_ext;
            FM_DISPX4: addend = sdisp_ext;
            default:   addend = index;
        endcase
        updated = base + addend;
    end
endmodule

// File: rtl/pul_extend.sv
// Extends right-justified load data to the register width by size code.
// Sign fill applies only to halfword and word; byte is always zero-filled
// and the full-width size passes data through. Assumes XLEN = 8 << 3.
module pul_extend #(
    parameter int XLEN   = 64,
    parameter int NSIZES = 4
) (
    input  logic [1:0]      size,
    input  logic            sgn,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] ext
);
    logic [XLEN-1:0] cand [NSIZES];

    // One candidate per access size; width and signability fixed per lane.
    for (genvar k = 0; k < NSIZES; k++) begin : g_lane
        localparam int  LW       = 8 << k;
        localparam bit  SIGNABLE = (k == 1) || (k == 2);
        if (LW >= XLEN) begin : g_full
            assign cand[k] = raw;
        end else begin : g_part
            logic fill;
            assign fill    = SIGNABLE ? (sgn & raw[LW-1]) : 1'b0;
            assign cand[k] = {{(XLEN-LW){fill}}, raw[LW-1:0]};
        end
    end

    // Pick the candidate for the requested size.
    always_comb begin
        ext = cand[size];
    end
endmodule

// File: rtl/pul_ctrl.sv
// Sequencer: accepts one operation while idle, holds a read request until
// taken, then waits for the response. A bad encoding yields a registered
// one-cycle pulse and no request. Assumes no response before request accept.
module pul_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_bad,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic op_ready,
    output logic accept_good,
    output logic mem_req_valid,
    output logic rsp_take,
    output logic invalid_pulse
);
    import pul_pkg::*;

    seq_state_e state_q, state_d;
    logic       accept;

    // Decode handshakes from the current state.
    always_comb begin
        op_ready      = (state_q == ST_IDLE);
        accept        = op_valid && op_ready;
        accept_good   = accept && !op_bad;
        mem_req_valid = (state_q == ST_REQ);
        rsp_take      = (state_q == ST_WAIT) && mem_rsp_valid;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept_good)   state_d = ST_REQ;
            ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State and invalid-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            invalid_pulse <= 1'b0;
        end else begin
            state_q       <= state_d;
            invalid_pulse <= accept && op_bad;
        end
    end
endmodule

// File: rtl/postinc_load_unit.sv
// Post-update integer load unit. Reads memory at the unmodified base value,
// extends the returned data into the target register, and writes the
// offset-adjusted base back on a second port in the same response cycle.
// Assumes aligned accesses and big-endian right-justified read data.
module postinc_load_unit #(
    parameter int XLEN    = 64,
    parameter int IDX_W   = 5,
    parameter int DISP_W  = 16,
    parameter int SDISP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [1:0]        op_form,
    input  logic [DISP_W-1:0] op_imm,
    input  logic [IDX_W-1:0]  op_base_idx,
    input  logic [IDX_W-1:0]  op_tgt_idx,
    input  logic [XLEN-1:0]   op_base_val,
    input  logic [XLEN-1:0]   op_index_val,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_data,
    output logic              wb_tgt_we,
    output logic [IDX_W-1:0]  wb_tgt_idx,
    output logic [XLEN-1:0]   wb_tgt_data,
    output logic              wb_base_we,
    output logic [IDX_W-1:0]  wb_base_idx,
    output logic [XLEN-1:0]   wb_base_data,
    output logic              invalid_form
);
    logic             op_bad;
    logic             accept_good;
    logic             rsp_take;
    logic [XLEN-1:0]  upd_now;

    logic [1:0]       size_q;
    logic             sgn_q;
    logic [IDX_W-1:0] tgt_q;
    logic [IDX_W-1:0] base_q;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  upd_q;

    // Flag encodings that name register zero as base or alias base and target.
    always_comb begin
        op_bad = (op_base_idx == '0) || (op_base_idx == op_tgt_idx);
    end

    pul_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_bad        (op_bad),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .op_ready      (op_ready),
        .accept_good   (accept_good),
        .mem_req_valid (mem_req_valid),
        .rsp_take      (rsp_take),
        .invalid_pulse (invalid_form)
    );

    pul_addr_calc #(
        .XLEN    (XLEN),
        .DISP_W  (DISP_W),
        .SDISP_W (SDISP_W)
    ) u_addr (
        .form    (op_form),
        .imm     (op_imm),
        .base    (op_base_val),
        .index   (op_index_val),
        .updated (upd_now)
    );

    // Capture the operation on acceptance so inputs may change afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            sgn_q  <= 1'b0;
            tgt_q  <= '0;
            base_q <= '0;
            addr_q <= '0;
            upd_q  <= '0;
        end else if (accept_good) begin
            size_q <= op_size;
            sgn_q  <= op_signed;
            tgt_q  <= op_tgt_idx;
            base_q <= op_base_idx;
            addr_q <= op_base_val;
            upd_q  <= upd_now;
        end
    end

    pul_extend #(
        .XLEN (XLEN)
    ) u_ext (
        .size (size_q),
        .sgn  (sgn_q),
        .raw  (mem_rsp_data),
        .ext  (wb_tgt_data)
    );

    // Drive the request fields and both writeback ports.
    always_comb begin
        mem_req_addr = addr_q;
        mem_req_size = size_q;
        wb_tgt_we    = rsp_take;
        wb_tgt_idx   = tgt_q;
        wb_base_we   = rsp_take;
        wb_base_idx  = base_q;
        wb_base_data = upd_q;
    end
endmodule

// File: rtl/pul_checks.sv
// Protocol checker for postinc_load_unit, bound to every instance.
// Observes ports only; assumes synchronous active-low reset.
module pul_checks #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            wb_tgt_we,
    input logic            wb_base_we,
    input logic            invalid_form
);
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r9_no_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_form |-> !mem_req_valid && !wb_tgt_we && !wb_base_we);

    a_r9_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_form |-> $past(op_valid && op_ready));

    a_r10_paired: assert property (@(posedge clk) disable iff (!rst_n)
        wb_tgt_we |-> wb_base_we && mem_rsp_valid);

    a_r10_base_paired: assert property (@(posedge clk) disable iff (!rst_n)
        wb_base_we |-> wb_tgt_we);

    a_r10_wb_ends: assert property (@(posedge clk) disable iff (!rst_n)
        wb_tgt_we |=> op_ready && !wb_tgt_we);

    a_r11_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

    a_r11_busy_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_tgt_we |-> !op_ready);
endmodule

bind postinc_load_unit pul_checks #(.XLEN(XLEN)) u_chk (.*);

// File: tb/postinc_load_unit_tb.sv
`timescale 1ns/1ps
module postinc_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic        op_ready;
    logic [1:0]  op_size;
    logic        op_signed;
    logic [1:0]  op_form;
    logic [15:0] op_imm;
    logic [4:0]  op_base_idx, op_tgt_idx;
    logic [63:0] op_base_val, op_index_val;
    logic        mem_req_valid, mem_req_ready;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        wb_tgt_we, wb_base_we, invalid_form;
    logic [4:0]  wb_tgt_idx, wb_base_idx;
    logic [63:0] wb_tgt_data, wb_base_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    postinc_load_unit u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference extension: shift the lane to the top, then shift back down.
    function automatic logic [63:0] ref_ext(input int sz, input bit sg, input logic [63:0] d);
        int sh = 64 - (8 << sz);
        logic [63:0] up = d << sh;
        if (sh == 0) return d;
        if (sg && (sz == 1 || sz == 2)) return 64'($signed(up) >>> sh);
        return up >> sh;
    endfunction

    // Reference update address by form code.
    function automatic logic [63:0] ref_upd(input int fm, input logic [15:0] imm,
                                            input logic [63:0] b, input logic [63:0] ix);
        case (fm)
            0:       return b + 64'(longint'(shortint'(imm)));
            1:       return b + 64'(longint'(shortint'({imm[13:0], 2'b00})));
            default: return b + ix;
        endcase
    endfunction

    task automatic run_op(input string rq, input int sz, input bit sg, input int fm,
                          input logic [15:0] imm, input logic [4:0] bi, input logic [4:0] ti,
                          input logic [63:0] bv, input logic [63:0] iv, input logic [63:0] md,
                          input int req_lat, input int rsp_lat);
        bit bad = (bi == 0) || (bi == ti);
        logic [63:0] exp_d = ref_ext(sz, sg, md);
        logic [63:0] exp_u = ref_upd(fm, imm, bv, iv);
        @(negedge clk);
        chk("R11", "ready before op", 64'(op_ready), 64'd1);
        op_valid = 1; op_size = 2'(sz); op_signed = sg; op_form = 2'(fm);
        op_imm = imm; op_base_idx = bi; op_tgt_idx = ti; op_base_val = bv; op_index_val = iv;
        @(negedge clk);
        op_valid = 0; op_base_val = ~bv; op_index_val = ~iv; op_imm = ~imm;
        op_size = ~op_size; op_signed = ~sg; op_base_idx = ~bi; op_tgt_idx = ~ti;
        #1;
        if (bad) begin
            chk("R9", "invalid pulse", 64'(invalid_form), 64'd1);
            chk("R9", "no request", 64'(mem_req_valid), 64'd0);
            chk("R9", "no writeback", 64'({wb_tgt_we, wb_base_we}), 64'd0);
            @(negedge clk); #1;
            chk("R9", "pulse one cycle", 64'(invalid_form), 64'd0);
            chk("R9", "still no request", 64'(mem_req_valid), 64'd0);
            return;
        end
        chk("R9", "no pulse on valid form", 64'(invalid_form), 64'd0);
        for (int c = 0; c <= req_lat; c++) begin
            chk("R1", "req valid", 64'(mem_req_valid), 64'd1);
            chk({"R1 ", rq}, "req addr", mem_req_addr, bv);
            chk("R1", "req size", 64'(mem_req_size), 64'(sz));
            chk("R11", "busy in req", 64'(op_ready), 64'd0);
            if (c == req_lat) mem_req_ready = 1;
            @(negedge clk);
        end
        mem_req_ready = 0;
        #1;
        chk("R11", "single request", 64'(mem_req_valid), 64'd0);
        for (int c = 0; c < rsp_lat; c++) begin
            chk("R10", "no early wb", 64'({wb_tgt_we, wb_base_we}), 64'd0);
            chk("R11", "busy in wait", 64'(op_ready), 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1; mem_rsp_data = md;
        #1;
        chk("R10", "both we", 64'({wb_tgt_we, wb_base_we}), 64'd3);
        chk("R10", "tgt idx", 64'(wb_tgt_idx), 64'(ti));
        chk("R10", "base idx", 64'(wb_base_idx), 64'(bi));
        chk(rq, "tgt data", wb_tgt_data, exp_d);
        chk(rq, "base data", wb_base_data, exp_u);
        chk("R11", "busy in rsp", 64'(op_ready), 64'd0);
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = ~md;
        #1;
        chk("R11", "ready after rsp", 64'(op_ready), 64'd1);
        chk("R10", "wb ends", 64'({wb_tgt_we, wb_base_we}), 64'd0);
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_valid = 0; op_size = 0; op_signed = 0; op_form = 0; op_imm = 0;
        op_base_idx = 0; op_tgt_idx = 0; op_base_val = 0; op_index_val = 0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R12", "reset ready", 64'(op_ready), 64'd1);
        chk("R12", "reset req", 64'(mem_req_valid), 64'd0);
        chk("R12", "reset wb", 64'({wb_tgt_we, wb_base_we}), 64'd0);
        chk("R12", "reset invalid", 64'(invalid_form), 64'd0);

        // R2 byte zero / signed-ignored, R6 displacement both signs
        run_op("R2_R6", 0, 0, 0, 16'h0010, 5'd3, 5'd4, 64'h0000_1000_0000_2000, 64'h0, 64'h1122334455667788, 0, 0);
        run_op("R2_R6", 0, 1, 0, 16'hFFF0, 5'd5, 5'd6, 64'h0000_0000_0000_0008, 64'h0, 64'hFFFFFFFFFFFFFF80, 2, 1);
        // R3 halfword, R7 scaled displacement with ignored top imm bits
        run_op("R3_R7", 1, 0, 1, 16'hC005, 5'd7, 5'd8, 64'h0000_0000_0000_4000, 64'h0, 64'h0000000000008001, 1, 2);
        run_op("R3_R7", 1, 1, 1, 16'h2000, 5'd9, 5'd1, 64'h0000_0000_0001_0000, 64'h0, 64'h0000000000008001, 0, 3);
        run_op("R3", 1, 1, 0, 16'h7FFF, 5'd31, 5'd30, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h0000000000007FFE, 0, 0);
        // R4 word, R8 indexed including wraparound
        run_op("R4_R8", 2, 0, 2, 16'h1234, 5'd10, 5'd11, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0004, 64'h0000000089ABCDEF, 3, 0);
        run_op("R4_R8", 2, 1, 2, 16'h0000, 5'd12, 5'd13, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_0000_0008, 64'h0000000089ABCDEF, 0, 1);
        // R5 doubleword with sign select, R8 reserved form as indexed
        run_op("R5_R8", 3, 1, 3, 16'h0008, 5'd14, 5'd15, 64'h1000, 64'hFFFF_FFFF_FFFF_FF00, 64'h8765432101234567, 1, 1);
        // R9 invalid encodings, then a valid op right after
        run_op("R9", 2, 0, 0, 16'h0004, 5'd0, 5'd3, 64'h2000, 64'h0, 64'h0, 0, 0);
        run_op("R9", 1, 1, 2, 16'h0004, 5'd17, 5'd17, 64'h2000, 64'h10, 64'h0, 0, 0);
        run_op("R9", 3, 0, 1, 16'h0000, 5'd0, 5'd0, 64'h2000, 64'h0, 64'h0, 0, 0);
        run_op("R10", 0, 0, 2, 16'h0000, 5'd20, 5'd21, 64'h3000, 64'h1, 64'h00000000000000A5, 4, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule